// File: doc/BRIEF.md
# Write Burst Stop Decision Unit

This unit sits on the target side of a bus bridge. For each data phase of an incoming write burst, it decides whether to take the data and continue, to take the data and end the burst with a target disconnect, or to refuse the transaction with a target retry. The decision depends on the kind of write, the current DWORD address, the configured cache line size, a disconnect-control configuration bit, free space in the posted-write FIFO, the number of open delayed-transaction queue entries, and a fast back-to-back indication with its per-direction enable bits.

Each data phase is presented for one cycle. The three result strobes are registered and appear one clock after the phase. Bus signalling, data storage and read handling live elsewhere.

Top module: `wr_stop_ctrl`

## Requirements
- R1: While rst_ni is low, accept_o, disconnect_o and retry_o are all 0. An asynchronous reset in the middle of a run also clears all three.
- R2: The strobes follow the phase that was presented one clock earlier. A cycle with phase_valid_i low produces all three strobes at 0 one clock later.
- R3: kind_i 2'b00 is a delayed write. If dq_open_i is nonzero, its first phase is accepted with disconnect. If dq_open_i is 0, its first phase is retried. A delayed write on a later phase is accepted with disconnect.
- R4: kind_i 2'b01 (and the unused code 2'b11) is a posted memory write. With wdc_ctl_i at 0 it keeps accepting and disconnects on the phase whose address bits 11:2 are all ones, the last DWORD before a 4KB boundary.
- R5: A posted memory write with wdc_ctl_i at 1 and a legal line size disconnects on the phase whose address bits covering the line (bits 2 up to log2(size)+1) are all ones. Legal line sizes are 1, 2, 4, 8 and 16 DWORDs. With an illegal line size, it falls back to the 4KB rule.
- R6: kind_i 2'b10 is a memory write and invalidate. With an illegal line size it disconnects only at the 4KB rule of R4.
- R7: A memory write and invalidate with a legal line size disconnects on the last DWORD of a line only when the FIFO space left after that DWORD (fifo_free_i minus 1) is less than the line size. Otherwise, including at a 4KB boundary, it continues.
- R8: An accepted posted or invalidate phase with fifo_free_i equal to 1 always carries disconnect.
- R9: The first phase of a posted or invalidate write with fifo_free_i at 0 is retried. A later phase with fifo_free_i at 0 gets disconnect without accept.
- R10: On a first phase with fbb_i high, the write is accepted only if the enable bit for its direction is set: fbb_en_up_i when upstream_i is 1, fbb_en_dn_i otherwise. If that bit is clear, or if there is no buffer room for the write, it is retried. fbb_i has no effect on later phases.
- R11: retry_o and disconnect_o are never high together. retry_o only follows a first phase. accept_o and retry_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_valid_i | input | 1 | A write data phase is offered this cycle |
| first_phase_i | input | 1 | The offered phase is the first of its transaction |
| kind_i | input | 2 | Write kind: 00 delayed, 01/11 posted, 10 invalidate |
| upstream_i | input | 1 | Direction of the transaction: 1 upstream, 0 downstream |
| fbb_i | input | 1 | Transaction arrived fast back-to-back |
| fbb_en_up_i | input | 1 | Fast back-to-back enable for upstream writes |
| fbb_en_dn_i | input | 1 | Fast back-to-back enable for downstream writes |
| addr_i | input | ADDR_W | Byte address of the current DWORD |
| line_size_i | input | LS_W | Cache line size in DWORDs |
| wdc_ctl_i | input | 1 | Disconnect-control bit for posted memory writes |
| fifo_free_i | input | FREE_W | Free DWORD slots in the posted-write FIFO |
| dq_open_i | input | DQ_W | Open delayed-transaction queue entries |
| accept_o | output | 1 | Phase data taken |
| disconnect_o | output | 1 | End the burst with a target disconnect |
| retry_o | output | 1 | Refuse the transaction with a target retry |

## Verification
The assertions assume that the inputs are steady around each rising edge. They also assume that first_phase_i marks exactly the opening phase of each transaction, and that fifo_free_i and dq_open_i describe the room available at that moment. The bench drives every input on the falling edge and presents one phase per cycle. It also separates phases with idle cycles, so each phase sees a consistent set of values. The line-end cases use addresses chosen so that the 4KB rule and the cache-line rule give different answers. The FIFO counts sit on either side of the line size to test the free-space rule for memory write and invalidate.

// File: rtl/wr_stop_pkg.sv
package wr_stop_pkg;
  typedef enum logic [1:0] {
    KIND_DLY = 2'b00,
    KIND_PMW = 2'b01,
    KIND_MWI = 2'b10,
    KIND_RSV = 2'b11
  } wr_kind_e;

  typedef struct packed {
    logic accept;
    logic disc;
    logic retry;
  } wr_dec_t;

  localparam int unsigned PAGE_HI  = 11;
  localparam int unsigned LINE_MAX_LOG = 4;
endpackage

// File: rtl/wr_line_decode.sv
module wr_line_decode
  import wr_stop_pkg::*;
#(
  parameter int unsigned LS_W = 8
) (
  input  logic [LS_W-1:0]         line_size_i,
  output logic                    legal_o,
  output logic [LINE_MAX_LOG-1:0] mask_o
);
  always_comb begin
    legal_o = 1'b0;
    mask_o  = '0;
    for (int k = 0; k <= LINE_MAX_LOG; k++) begin
      if (line_size_i == LS_W'(1 << k)) begin
        legal_o = 1'b1;
        mask_o  = LINE_MAX_LOG'((1 << k) - 1);
      end
    end
  end
endmodule

// File: rtl/wr_boundary_detect.sv
module wr_boundary_detect
  import wr_stop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LINE_MAX_LOG-1:0] mask_i,
  output logic                    page_end_o,
  output logic                    line_end_o
);
  localparam int unsigned LINE_HI = 2 + LINE_MAX_LOG - 1;

  // last DWORD before the boundary: the next address wraps these bits to zero
  assign page_end_o = &addr_i[PAGE_HI:2];
  assign line_end_o = &(addr_i[LINE_HI:2] | ~mask_i);
endmodule

// File: rtl/wr_admit.sv
module wr_admit
  import wr_stop_pkg::*;
#(
  parameter int unsigned LS_W   = 8,
  parameter int unsigned FREE_W = 8,
  parameter int unsigned DQ_W   = 3
) (
  input  logic              phase_valid_i,
  input  logic              first_phase_i,
  input  wr_kind_e          kind_i,
  input  logic              upstream_i,
  input  logic              fbb_i,
  input  logic              fbb_en_up_i,
  input  logic              fbb_en_dn_i,
  input  logic              wdc_ctl_i,
  input  logic [LS_W-1:0]   line_size_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  input  logic [DQ_W-1:0]   dq_open_i,
  input  logic              legal_i,
  input  logic              page_end_i,
  input  logic              line_end_i,
  output wr_dec_t           dec_o
);
  localparam int unsigned CW = ((LS_W > FREE_W) ? LS_W : FREE_W) + 1;

  logic is_dly, is_mwi, no_room, fbb_ok, low_room, stop;
  logic [CW-1:0] room_after;

  assign is_dly = (kind_i == KIND_DLY);
  assign is_mwi = (kind_i == KIND_MWI);
  assign no_room = is_dly ? (dq_open_i == '0) : (fifo_free_i == '0);
  assign fbb_ok  = upstream_i ? fbb_en_up_i : fbb_en_dn_i;
  assign room_after = CW'(fifo_free_i) - CW'(1);
  assign low_room   = room_after < CW'(line_size_i);

  always_comb begin
    if (is_dly)                       stop = 1'b1;
    else if (fifo_free_i == FREE_W'(1)) stop = 1'b1;
    else if (is_mwi)                  stop = legal_i ? (line_end_i && low_room) : page_end_i;
    else if (wdc_ctl_i && legal_i)    stop = line_end_i;
    else                              stop = page_end_i;
  end

  always_comb begin
    dec_o = '0;
    if (phase_valid_i) begin
      if (first_phase_i && (no_room || (fbb_i && !fbb_ok))) begin
        dec_o.retry = 1'b1;
      end else if (!is_dly && fifo_free_i == '0) begin
        dec_o.disc = 1'b1;
      end else begin
        dec_o.accept = 1'b1;
        dec_o.disc   = stop;
      end
    end
  end
endmodule

// File: rtl/wr_stop_ctrl.sv
module wr_stop_ctrl
  import wr_stop_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LS_W   = 8,
  parameter int unsigned FREE_W = 8,
  parameter int unsigned DQ_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_valid_i,
  input  logic              first_phase_i,
  input  logic [1:0]        kind_i,
  input  logic              upstream_i,
  input  logic              fbb_i,
  input  logic              fbb_en_up_i,
  input  logic              fbb_en_dn_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LS_W-1:0]   line_size_i,
  input  logic              wdc_ctl_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  input  logic [DQ_W-1:0]   dq_open_i,
  output logic              accept_o,
  output logic              disconnect_o,
  output logic              retry_o
);
  logic                    legal;
  logic [LINE_MAX_LOG-1:0] mask;
  logic                    page_end, line_end;
  wr_dec_t                 dec_d, dec_q;

  wr_line_decode #(.LS_W(LS_W)) i_line_decode (
    .line_size_i(line_size_i),
    .legal_o    (legal),
    .mask_o     (mask)
  );

  wr_boundary_detect #(.ADDR_W(ADDR_W)) i_boundary_detect (
    .addr_i    (addr_i),
    .mask_i    (mask),
    .page_end_o(page_end),
    .line_end_o(line_end)
  );

  wr_admit #(.LS_W(LS_W), .FREE_W(FREE_W), .DQ_W(DQ_W)) i_admit (
    .phase_valid_i(phase_valid_i),
    .first_phase_i(first_phase_i),
    .kind_i       (wr_kind_e'(kind_i)),
    .upstream_i   (upstream_i),
    .fbb_i        (fbb_i),
    .fbb_en_up_i  (fbb_en_up_i),
    .fbb_en_dn_i  (fbb_en_dn_i),
    .wdc_ctl_i    (wdc_ctl_i),
    .line_size_i  (line_size_i),
    .fifo_free_i  (fifo_free_i),
    .dq_open_i    (dq_open_i),
    .legal_i      (legal),
    .page_end_i   (page_end),
    .line_end_i   (line_end),
    .dec_o        (dec_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dec_q <= '0;
    else         dec_q <= dec_d;
  end

  assign accept_o     = dec_q.accept;
  assign disconnect_o = dec_q.disc;
  assign retry_o      = dec_q.retry;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !(accept_o || disconnect_o || retry_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_valid_i |=> !(accept_o || disconnect_o || retry_o));

  assert_retry_disc_mutex_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retry_o && (disconnect_o || accept_o)));

  assert_retry_first_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_valid_i && !first_phase_i) |=> !retry_o);

  assert_dly_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_valid_i && kind_i == KIND_DLY) |=> (retry_o || disconnect_o));

  assert_full_fifo_no_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_valid_i && kind_i != KIND_DLY && fifo_free_i == '0) |=> !accept_o);

  assert_last_slot_disc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_valid_i && kind_i != KIND_DLY && fifo_free_i == FREE_W'(1)) |=>
      (retry_o || (accept_o && disconnect_o)));
endmodule

// File: tb/test_wr_stop_ctrl.sv
`timescale 1ns/1ps
module test_wr_stop_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phase_valid_i = 1'b0, first_phase_i = 1'b0;
  logic [1:0]  kind_i = 2'b00;
  logic        upstream_i = 1'b0, fbb_i = 1'b0, fbb_en_up_i = 1'b0, fbb_en_dn_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [7:0]  line_size_i = 8'd8;
  logic        wdc_ctl_i = 1'b0;
  logic [7:0]  fifo_free_i = 8'd100;
  logic [2:0]  dq_open_i = 3'd2;
  logic        accept_o, disconnect_o, retry_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  wr_stop_ctrl i_wr_stop_ctrl (.*);

  task automatic chk(input string tag, input logic a, input logic d, input logic r);
    checks++;
    if ({accept_o, disconnect_o, retry_o} !== {a, d, r}) begin
      fails++;
      $display("FAIL %s: got a/d/r=%b%b%b expected %b%b%b", tag,
               accept_o, disconnect_o, retry_o, a, d, r);
    end
  endtask

  // present one phase on the falling edge, sample just after the next rising edge
  task automatic phase(input logic first, input logic [1:0] kind, input logic [31:0] addr,
                       input logic [7:0] free, input string tag,
                       input logic a, input logic d, input logic r);
    @(negedge clk_i);
    phase_valid_i = 1'b1; first_phase_i = first; kind_i = kind;
    addr_i = addr; fifo_free_i = free;
    @(posedge clk_i); #2;
    chk(tag, a, d, r);
    @(negedge clk_i);
    phase_valid_i = 1'b0; first_phase_i = 1'b0; fbb_i = 1'b0;
    @(posedge clk_i); #2;
    chk({tag, " idle R2"}, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    #5 chk("R1 in reset", 1'b0, 1'b0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #2 chk("R1/R2 after release", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_delayed;
    dq_open_i = 3'd2;
    phase(1'b1, 2'b00, 32'h100, 8'd50, "R3 dly open", 1'b1, 1'b1, 1'b0);
    dq_open_i = 3'd0;
    phase(1'b1, 2'b00, 32'h100, 8'd50, "R3 dly full", 1'b0, 1'b0, 1'b1);
    phase(1'b0, 2'b00, 32'h104, 8'd50, "R3/R11 dly later", 1'b1, 1'b1, 1'b0);
    dq_open_i = 3'd2;
  endtask

  task automatic t_posted;
    wdc_ctl_i = 1'b0; line_size_i = 8'd8;
    phase(1'b1, 2'b01, 32'h101C, 8'd100, "R4 pmw line end no dc", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b01, 32'h0FF8, 8'd100, "R4 pmw near page", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b01, 32'h0FFC, 8'd100, "R4 pmw page end", 1'b1, 1'b1, 1'b0);
    phase(1'b0, 2'b11, 32'h1FFC, 8'd100, "R4 rsv kind page end", 1'b1, 1'b1, 1'b0);
    wdc_ctl_i = 1'b1;
    phase(1'b0, 2'b01, 32'h1018, 8'd100, "R5 pmw dc mid line", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b01, 32'h101C, 8'd100, "R5 pmw dc line end", 1'b1, 1'b1, 1'b0);
    line_size_i = 8'd16;
    phase(1'b0, 2'b01, 32'h101C, 8'd100, "R5 pmw dc 16 mid", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b01, 32'h103C, 8'd100, "R5 pmw dc 16 end", 1'b1, 1'b1, 1'b0);
    line_size_i = 8'd1;
    phase(1'b0, 2'b01, 32'h1004, 8'd100, "R5 pmw dc size1", 1'b1, 1'b1, 1'b0);
    line_size_i = 8'd3;
    phase(1'b0, 2'b01, 32'h101C, 8'd100, "R5 pmw dc bad size", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b01, 32'h1FFC, 8'd100, "R5 pmw dc bad size page", 1'b1, 1'b1, 1'b0);
    wdc_ctl_i = 1'b0; line_size_i = 8'd8;
  endtask

  task automatic t_invalidate;
    line_size_i = 8'd5;
    phase(1'b1, 2'b10, 32'h203C, 8'd100, "R6 mwi bad size line", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b10, 32'h2FFC, 8'd100, "R6 mwi bad size page", 1'b1, 1'b1, 1'b0);
    line_size_i = 8'd8;
    phase(1'b0, 2'b10, 32'h201C, 8'd20, "R7 mwi room", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b10, 32'h201C, 8'd8, "R7 mwi short", 1'b1, 1'b1, 1'b0);
    phase(1'b0, 2'b10, 32'h201C, 8'd9, "R7 mwi exact", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b10, 32'h2010, 8'd8, "R7 mwi mid line", 1'b1, 1'b0, 1'b0);
    phase(1'b0, 2'b10, 32'h2FFC, 8'd50, "R7 mwi page room", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_fifo;
    phase(1'b0, 2'b01, 32'h3010, 8'd1, "R8 pmw last slot", 1'b1, 1'b1, 1'b0);
    phase(1'b0, 2'b10, 32'h3010, 8'd1, "R8 mwi last slot", 1'b1, 1'b1, 1'b0);
    phase(1'b1, 2'b01, 32'h3010, 8'd0, "R9 first full", 1'b0, 1'b0, 1'b1);
    phase(1'b0, 2'b01, 32'h3014, 8'd0, "R9/R11 later full", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_fbb;
    upstream_i = 1'b1; fbb_en_up_i = 1'b1; fbb_en_dn_i = 1'b0; fbb_i = 1'b1;
    phase(1'b1, 2'b01, 32'h4000, 8'd40, "R10 up enabled", 1'b1, 1'b0, 1'b0);
    fbb_en_up_i = 1'b0; fbb_en_dn_i = 1'b1; fbb_i = 1'b1;
    phase(1'b1, 2'b01, 32'h4000, 8'd40, "R10 up disabled", 1'b0, 1'b0, 1'b1);
    upstream_i = 1'b0; fbb_i = 1'b1;
    phase(1'b1, 2'b01, 32'h4000, 8'd40, "R10 dn enabled", 1'b1, 1'b0, 1'b0);
    fbb_i = 1'b1;
    phase(1'b1, 2'b01, 32'h4000, 8'd0, "R10 dn no room", 1'b0, 1'b0, 1'b1);
    fbb_en_dn_i = 1'b0; fbb_i = 1'b1;
    phase(1'b0, 2'b01, 32'h4004, 8'd40, "R10/R11 later ignores fbb", 1'b1, 1'b0, 1'b0);
    fbb_en_dn_i = 1'b0; upstream_i = 1'b0;
  endtask

  task automatic t_async_reset;
    @(negedge clk_i);
    phase_valid_i = 1'b1; first_phase_i = 1'b1; kind_i = 2'b00;
    @(posedge clk_i); #2 chk("R1 pre reset accept", 1'b1, 1'b1, 1'b0);
    #3 rst_ni = 1'b0;
    #1 chk("R1 async clear", 1'b0, 1'b0, 1'b0);
    @(negedge clk_i); phase_valid_i = 1'b0; first_phase_i = 1'b0; rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_delayed();
    t_posted();
    t_invalidate();
    t_fifo();
    t_fbb();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule